// File: doc/BRIEF.md
# Watchdog Timer with Mode Register

This block is a watchdog timer for a small microcontroller. Software sets it up through one write-only mode register and refreshes it with a strobe. The counter advances on count ticks from one of two sources: an internal RC oscillator tick or an external crystal tick. When the number of counted ticks reaches the timeout picked by a 2-bit tap field, the block raises a one-cycle reset request. If software refreshes the counter first, no request is raised.

Two low-power mode inputs, halt and stop, can each pause counting. Whether counting pauses in each mode is set by its own bit in the mode register. While counting is paused, the counter holds its value. The oscillators themselves are not part of the block. They are modelled as single-cycle tick pulses in the `clk_i` domain.

Top module: `wdt_ctrl`

## Requirements
- R1: After reset, the mode is: RC tick source, counting enabled in both halt and stop, and tap code 01 (256 ticks). The reset request output is low.
- R2: Bits [1:0] of the mode register set the timeout: 00=128, 01=256, 10=512, 11=2048 counted ticks. The cycle after the tick that completes the timeout, `wdt_rst_o` is high for exactly one cycle, and the count restarts from zero.
- R3: Bit 4 selects the count source: 0 counts `rc_tick_i`, 1 counts `xtal_tick_i`. The source that is not selected has no effect.
- R4: Bit 2 set to 1 lets counting continue while `halt_i` is high. Bit 2 set to 0 freezes the count, and no request is raised, while `halt_i` is high.
- R5: Bit 3 set to 1 lets counting continue while `stop_i` is high. Bit 3 set to 0 freezes the count, and no request is raised, while `stop_i` is high.
- R6: A `kick_i` pulse clears the count to zero, so a full timeout interval starts again. It takes priority over a tick that would complete the timeout in the same cycle.
- R7: A mode write that changes the tap field or the source bit clears the count. A write that changes only bits 3 and 2 keeps the count.
- R8: Bits 7 to 5 of a mode write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 8 | Mode register write data |
| kick_i | input | 1 | Refresh strobe |
| rc_tick_i | input | 1 | Internal RC oscillator tick |
| xtal_tick_i | input | 1 | Crystal clock tick |
| halt_i | input | 1 | Halt mode active |
| stop_i | input | 1 | Stop mode active |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
Directed runs feed a tick every cycle and measure the number of ticks up to the request for each tap code, which separates the four limits. Runs that feed only the source that is not selected show that it is ignored. Runs held in halt or stop with counting disabled show a frozen count: after release, the request comes after only the remaining ticks. Writes that change only the mode-gating bits, compared with writes that change the tap field, separate a kept count from a cleared one. A long random mix of writes, kicks, ticks and low-power levels is compared every cycle against a bench model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic       src_xtal;
    logic       stop_run;
    logic       halt_run;
    logic [1:0] tap;
  } wdt_mode_t;

  localparam wdt_mode_t MODE_RST = '{src_xtal: 1'b0, stop_run: 1'b1, halt_run: 1'b1, tap: 2'b01};

  // last tap jumps by 4x over the third
  function automatic int unsigned tap_limit(input logic [1:0] code, input int unsigned base);
    case (code)
      2'b00:   return base;
      2'b01:   return base * 2;
      2'b10:   return base * 4;
      default: return base * 16;
    endcase
  endfunction
endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output wdt_mode_t  mode_o,
  output logic       restart_o
);
  wdt_mode_t mode_q;
  wdt_mode_t mode_d;

  assign mode_d    = wdt_mode_t'(wdata_i[4:0]);
  assign restart_o = we_i && ((mode_d.tap != mode_q.tap) || (mode_d.src_xtal != mode_q.src_xtal));
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_RST;
    else if (we_i) mode_q <= mode_d;
  end

  assert_reserved_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_q == wdt_mode_t'($past(wdata_i[4:0])));
endmodule

// File: rtl/wdt_tick_gate.sv
module wdt_tick_gate
  import wdt_pkg::*;
(
  input  wdt_mode_t mode_i,
  input  logic      rc_tick_i,
  input  logic      xtal_tick_i,
  input  logic      halt_i,
  input  logic      stop_i,
  output logic      tick_o
);
  logic src_tick;
  logic paused;

  assign src_tick = mode_i.src_xtal ? xtal_tick_i : rc_tick_i;
  assign paused   = (halt_i && !mode_i.halt_run) || (stop_i && !mode_i.stop_run);
  assign tick_o   = src_tick && !paused;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_TICKS = 128,
  localparam int unsigned CNT_W     = $clog2(BASE_TICKS * 16)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [1:0]       tap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             fire_q;

  assign last   = CNT_W'(wdt_pkg::tap_limit(tap_i, BASE_TICKS) - 1);
  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q >= last) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  assert_fire_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> cnt_q == '0);
  assert_kick_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !fire_q);
  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q) && !fire_q);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int unsigned BASE_TICKS = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       kick_i,
  input  logic       rc_tick_i,
  input  logic       xtal_tick_i,
  input  logic       halt_i,
  input  logic       stop_i,
  output logic       wdt_rst_o
);
  import wdt_pkg::*;
  localparam int unsigned CNT_W = $clog2(BASE_TICKS * 16);

  wdt_mode_t        mode;
  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  wdt_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .mode_o   (mode),
    .restart_o(restart)
  );

  wdt_tick_gate u_gate (
    .mode_i     (mode),
    .rc_tick_i  (rc_tick_i),
    .xtal_tick_i(xtal_tick_i),
    .halt_i     (halt_i),
    .stop_i     (stop_i),
    .tick_o     (tick)
  );

  wdt_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .clr_i (kick_i || restart),
    .tap_i (mode.tap),
    .cnt_o (cnt),
    .fire_o(wdt_rst_o)
  );

  assert_halt_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !mode.halt_run && !kick_i && !cfg_we_i) |=> $stable(cnt) && !wdt_rst_o);
  assert_stop_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !mode.stop_run && !kick_i && !cfg_we_i) |=> $stable(cnt) && !wdt_rst_o);
  assert_restart_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[1:0] != mode.tap) |=> cnt == '0);
  assert_kick_no_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !wdt_rst_o);
endmodule

// File: tb/wdt_ctrl_tb.sv
module wdt_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic       kick_i = 1'b0;
  logic       rc_tick_i = 1'b0;
  logic       xtal_tick_i = 1'b0;
  logic       halt_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       wdt_rst_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench model state
  int   m_cnt = 0;
  bit   m_fire = 1'b0;
  bit   m_src = 1'b0, m_sen = 1'b1, m_hen = 1'b1;
  logic [1:0] m_tap = 2'b01;

  always #10 clk_i = ~clk_i;

  wdt_ctrl dut_i (.*);

  function automatic int lim_of(input logic [1:0] c);
    case (c)
      2'b00: return 128;
      2'b01: return 256;
      2'b10: return 512;
      default: return 2048;
    endcase
  endfunction

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  // advance model one edge from current inputs, then compare after edge
  task automatic step();
    bit tk, rs, fn;
    rs = cfg_we_i && ((cfg_wdata_i[1:0] != m_tap) || (cfg_wdata_i[4] != m_src));
    tk = (m_src ? xtal_tick_i : rc_tick_i) && !(halt_i && !m_hen) && !(stop_i && !m_sen);
    fn = 1'b0;
    if (kick_i || rs) m_cnt = 0;
    else if (tk) begin
      if (m_cnt >= lim_of(m_tap) - 1) begin m_cnt = 0; fn = 1'b1; end
      else m_cnt++;
    end
    m_fire = fn;
    if (cfg_we_i) begin
      m_src = cfg_wdata_i[4]; m_sen = cfg_wdata_i[3]; m_hen = cfg_wdata_i[2]; m_tap = cfg_wdata_i[1:0];
    end
    @(posedge clk_i);
    cyc++;
    @(negedge clk_i);
    chk(wdt_rst_o === m_fire, tag, int'(wdt_rst_o), int'(m_fire));
  endtask

  task automatic clear_in();
    cfg_we_i = 0; kick_i = 0; rc_tick_i = 0; xtal_tick_i = 0; halt_i = 0; stop_i = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we_i = 1; cfg_wdata_i = d; step(); cfg_we_i = 0;
  endtask

  task automatic kick();
    kick_i = 1; step(); kick_i = 0;
  endtask

  // ticks on chosen source each cycle; returns ticks until the request (or max)
  task automatic measure(input bit use_xtal, input int max_n, output int n);
    n = 0;
    rc_tick_i = !use_xtal; xtal_tick_i = use_xtal;
    while (n < max_n) begin
      step(); n++;
      if (wdt_rst_o) break;
    end
    rc_tick_i = 0; xtal_tick_i = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    tag = "R1";
    chk(wdt_rst_o === 1'b0, "R1 reset output", int'(wdt_rst_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: default RC source, 256-tick timeout
    measure(1'b0, 3000, n);
    chk(n == 256, "R1 default timeout", n, 256);
    step(); chk(wdt_rst_o === 1'b0, "R2 one-cycle pulse", int'(wdt_rst_o), 0);

    // R2: each tap on crystal source; R8: reserved bits set
    for (int c = 0; c < 4; c++) begin
      tag = "R2";
      wr(8'hE0 | 8'h10 | 8'h0C | 8'(c));
      kick();
      measure(1'b1, 3000, n);
      chk(n == lim_of(2'(c)), "R2/R8 tap timeout", n, lim_of(2'(c)));
    end

    // R3: unselected source ignored
    tag = "R3";
    wr(8'h1C); // xtal, tap 00
    kick();
    measure(1'b0, 400, n);
    chk(n == 400 && m_cnt == 0, "R3 rc ignored on xtal", n, 400);
    wr(8'h0C); // rc, tap 00 -> restart
    measure(1'b1, 400, n);
    chk(n == 400, "R3 xtal ignored on rc", n, 400);

    // R4: halt freeze then resume
    tag = "R4";
    wr(8'h08); // rc, halt disables, tap 00
    kick();
    rc_tick_i = 1; repeat (100) step();
    halt_i = 1; repeat (500) step();
    halt_i = 0;
    measure(1'b0, 400, n);
    chk(n == 28, "R4 halt held count", n, 28);

    // R5: stop freeze then resume
    tag = "R5";
    wr(8'h04);
    kick();
    rc_tick_i = 1; repeat (60) step();
    stop_i = 1; repeat (500) step();
    stop_i = 0;
    measure(1'b0, 400, n);
    chk(n == 68, "R5 stop held count", n, 68);
    // R4/R5 enabled: counting continues in both modes
    tag = "R4";
    wr(8'h0C); kick();
    halt_i = 1; stop_i = 1;
    measure(1'b0, 400, n);
    chk(n == 128, "R4/R5 run in halt+stop", n, 128);
    halt_i = 0; stop_i = 0;

    // R6: kick on completing tick wins
    tag = "R6";
    kick();
    rc_tick_i = 1; repeat (127) step();
    kick_i = 1; step(); kick_i = 0;
    chk(wdt_rst_o === 1'b0, "R6 kick beats timeout", int'(wdt_rst_o), 0);
    measure(1'b0, 400, n);
    chk(n == 128, "R6 full interval after kick", n, 128);

    // R7: gating-only write keeps count, tap write clears
    tag = "R7";
    rc_tick_i = 1; repeat (50) step(); rc_tick_i = 0;
    wr(8'h00); // only halt/stop bits change
    measure(1'b0, 400, n);
    chk(n == 78, "R7 gating write keeps count", n, 78);
    rc_tick_i = 1; repeat (50) step(); rc_tick_i = 0;
    wr(8'h01); wr(8'h00);
    measure(1'b0, 400, n);
    chk(n == 128, "R7 tap write clears", n, 128);

    // random mix against model
    tag = "R2 random";
    for (int i = 0; i < 12000; i++) begin
      clear_in();
      cfg_we_i = ($urandom_range(0, 399) == 0);
      cfg_wdata_i = 8'($urandom) & 8'hF3 | ($urandom_range(0, 3) == 0 ? 8'h01 : 8'h00);
      if (cfg_we_i) cfg_wdata_i[1:0] = 2'($urandom_range(0, 1));
      kick_i = ($urandom_range(0, 499) == 0);
      rc_tick_i = ($urandom_range(0, 1) == 0);
      xtal_tick_i = ($urandom_range(0, 1) == 0);
      halt_i = ($urandom_range(0, 7) == 0);
      stop_i = ($urandom_range(0, 7) == 0);
      step();
    end
    clear_in();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule